// File: doc/BRIEF.md
# Flash Row Program and Page Erase Controller

This block sits between a processor's register bus and an on-chip program flash array. Software first fills a holding buffer of one row of instruction words. Each word takes two register writes, the low 16 bits and then the upper bits. Software then writes a two-value key and sets a start bit. The controller then runs either a row program or a page erase. A row program streams the buffered words to the array. A page erase issues one erase command at an aligned page address.

While the operation runs, the controller raises a stall output that holds the processor. The stall lasts for a fixed, parameterised number of clock cycles. When the operation ends, the start bit clears on its own.

The controller rejects a request and records the cause in one of three sticky error flags:
- a start without a correct unlock,
- a misaligned erase address,
- a badly ordered or incomplete buffer fill.

Addresses are word addresses. One row is 64 words, which is 192 bytes at three bytes per word. One page is 8 rows, which is 512 words or 1536 bytes.

Top module: `nvm_row_ctrl`

## Requirements
- R1: After reset, stall, fl_wr_en and fl_erase are low, and a control register read (reg_sel 0) returns zero.
- R2: A read of the key register (reg_sel 1) always returns zero.
- R3: A start is accepted only when the two register writes just before it were key (reg_sel 1) writes of 0x0055 and then 0x00AA. Any other value, or any other write between them, breaks the sequence. A start without a valid unlock is ignored and sets the key-error flag, control bit 14.
- R4: Control bit 15 is the start bit. Control bit 0 selects the operation: 0 for row program, 1 for page erase. Bit 0 of the last control write reads back at bit 0.
- R5: An accepted start raises stall in the next cycle and holds it for exactly OP_CYCLES cycles. Control bit 15 reads 1 while stall is high and 0 afterwards.
- R6: For a row program, fl_wr_en is high in the first ROW_WORDS stall cycles. In cycle k it presents fl_addr = row base + k and fl_wdata = buffered word k.
- R7: A page erase pulses fl_erase for one cycle, in the first stall cycle, with fl_addr at the page base. The erase address must be a multiple of ROW_WORDS*PAGE_ROWS words. Otherwise the request is rejected and control bit 12, the alignment error, is set.
- R8: A buffer write with reg_sel 2 loads bits 15:0 of a word. A write with reg_sel 3 loads the upper WORD_W-16 bits. Each word must get its low write and then its high write, at consecutive addresses that start at a row-aligned address within one row. A load that breaks this order is not stored and sets control bit 13, the sequence error.
- R9: A row program request is rejected, and bit 13 is set, if the sequence error is already set or if the buffer does not hold a full row.
- R10: A control write with bit 15 clear clears bits 14, 13 and 12 and rewinds the buffer fill. The end of a row program also rewinds the fill.
- R11: All register writes made while stall is high are ignored. This includes key writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 key, 2 buffer low, 3 buffer high |
| reg_addr | input | ADDR_W | Word address for buffer loads and for the erase target |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data, combinational, zero when not reading |
| stall | output | 1 | Processor stall, high while an operation runs |
| fl_wr_en | output | 1 | Array word write strobe |
| fl_erase | output | 1 | Array page erase strobe |
| fl_addr | output | ADDR_W | Array word address |
| fl_wdata | output | WORD_W | Array write data |

## Verification
A register read returns its value in the same cycle as the strobe. A write takes effect at the clock edge that samples it.

An accepted start therefore shows stall from the cycle after that edge. Flash word k of a row program appears k cycles after that. fl_erase is in the first stall cycle. Stall falls OP_CYCLES cycles after it rose, and any error flag is readable from the cycle after the offending write.

The bench drives inputs on the falling edge. It compares every output with a behavioural model 5 ns later, so each result is sampled in the cycle in which it is due. Scenario reads and edge counters then confirm the flag values and the stall and stream lengths.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

   // register select codes on the bus
   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_KEY    = 2'd1,
      SEL_BUF_LO = 2'd2,
      SEL_BUF_HI = 2'd3
   } reg_sel_e;

   // unlock tracker states
   typedef enum logic [1:0] {
      KEY_IDLE  = 2'd0,
      KEY_HALF  = 2'd1,
      KEY_ARMED = 2'd2
   } key_state_e;

   localparam logic [7:0] KEY_FIRST  = 8'h55;
   localparam logic [7:0] KEY_SECOND = 8'hAA;

endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock #(
   parameter int REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       sel,
   input  logic [REG_W-1:0] wdata,
   output logic             armed
);
   import nvm_pkg::*;

   key_state_e st_q, st_d;
   logic       is_key, is_first, is_second;

   always_comb begin
      is_key    = (sel == SEL_KEY);
      is_first  = is_key && (wdata == REG_W'(KEY_FIRST));
      is_second = is_key && (wdata == REG_W'(KEY_SECOND));
      st_d      = st_q;
      if (wr_en) begin
         if (is_first)
            st_d = KEY_HALF;
         else if (is_second && (st_q == KEY_HALF))
            st_d = KEY_ARMED;
         else
            st_d = KEY_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= KEY_IDLE;
      else        st_q <= st_d;
   end

   assign armed = (st_q == KEY_ARMED);

endmodule

// File: rtl/nvm_fill_buf.sv
module nvm_fill_buf #(
   parameter int WORD_W    = 24,
   parameter int REG_W     = 16,
   parameter int ROW_WORDS = 64,
   parameter int ADDR_W    = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ld_en,
   input  logic                         ld_hi,
   input  logic [ADDR_W-1:0]            ld_addr,
   input  logic [REG_W-1:0]             ld_data,
   input  logic                         clr,
   input  logic                         flag_err,
   input  logic [$clog2(ROW_WORDS)-1:0] rd_idx,
   output logic [WORD_W-1:0]            rd_word,
   output logic                         full,
   output logic                         seq_err,
   output logic [ADDR_W-1:0]            grp_base
);
   localparam int ROW_LG = $clog2(ROW_WORDS);
   localparam int HI_W   = WORD_W - REG_W;
   localparam int GRP_W  = ADDR_W - ROW_LG;
   localparam int FILL_W = ROW_LG + 1;

   logic [FILL_W-1:0]           fill_q;
   logic                        half_q;
   logic [GRP_W-1:0]            grp_q;
   logic                        err_q;
   logic                        idx_ok, grp_ok, room, phase_ok, ld_ok, ld_bad;
   logic [ROW_WORDS-1:0]        wr_lo, wr_hi;
   logic [ROW_WORDS*WORD_W-1:0] flat;

   always_comb begin
      idx_ok   = (ld_addr[ROW_LG-1:0] == fill_q[ROW_LG-1:0]);
      grp_ok   = ((fill_q == '0) && !half_q) || (ld_addr[ADDR_W-1:ROW_LG] == grp_q);
      room     = (fill_q < FILL_W'(ROW_WORDS));
      phase_ok = (ld_hi == half_q);
      ld_ok    = ld_en && room && idx_ok && grp_ok && phase_ok;
      ld_bad   = ld_en && !ld_ok;
      wr_lo    = (ld_ok && !ld_hi) ? (ROW_WORDS'(1) << fill_q[ROW_LG-1:0]) : '0;
      wr_hi    = (ld_ok &&  ld_hi) ? (ROW_WORDS'(1) << fill_q[ROW_LG-1:0]) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q <= '0;
         half_q <= 1'b0;
         grp_q  <= '0;
         err_q  <= 1'b0;
      end else if (clr) begin
         fill_q <= '0;
         half_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (ld_ok) begin
            if (!ld_hi) begin
               half_q <= 1'b1;
               if (fill_q == '0) grp_q <= ld_addr[ADDR_W-1:ROW_LG];
            end else begin
               half_q <= 1'b0;
               fill_q <= fill_q + FILL_W'(1);
            end
         end
         if (ld_bad || flag_err) err_q <= 1'b1;
      end
   end

   // one storage slot per row word
   for (genvar s = 0; s < ROW_WORDS; s++) begin : g_slot
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else begin
            if (wr_lo[s]) word_q[REG_W-1:0]      <= ld_data;
            if (wr_hi[s]) word_q[WORD_W-1:REG_W] <= ld_data[HI_W-1:0];
         end
      end
      assign flat[s*WORD_W +: WORD_W] = word_q;
   end

   assign rd_word  = flat[rd_idx*WORD_W +: WORD_W];
   assign full     = (fill_q == FILL_W'(ROW_WORDS));
   assign seq_err  = err_q;
   assign grp_base = {grp_q, {ROW_LG{1'b0}}};

endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer #(
   parameter int ROW_WORDS = 64,
   parameter int ADDR_W    = 16,
   parameter int OP_CYCLES = 200000
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic                         start_erase,
   input  logic [ADDR_W-1:0]            start_addr,
   output logic                         busy,
   output logic                         done,
   output logic                         fl_wr_en,
   output logic                         fl_erase,
   output logic [ADDR_W-1:0]            fl_addr,
   output logic [$clog2(ROW_WORDS)-1:0] rd_idx
);
   localparam int ROW_LG = $clog2(ROW_WORDS);
   localparam int CNT_W  = $clog2(OP_CYCLES + 1);

   logic              busy_q, erase_q, last, stream;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         erase_q <= 1'b0;
         cnt_q   <= '0;
         base_q  <= '0;
      end else if (start) begin
         busy_q  <= 1'b1;
         erase_q <= start_erase;
         cnt_q   <= '0;
         base_q  <= start_addr;
      end else if (busy_q) begin
         if (last) busy_q <= 1'b0;
         else      cnt_q  <= cnt_q + CNT_W'(1);
      end
   end

   always_comb begin
      last     = busy_q && (cnt_q == CNT_W'(OP_CYCLES - 1));
      stream   = busy_q && !erase_q && (cnt_q < CNT_W'(ROW_WORDS));
      rd_idx   = cnt_q[ROW_LG-1:0];
      fl_wr_en = stream;
      fl_erase = busy_q && erase_q && (cnt_q == '0);
      if (stream)        fl_addr = base_q + ADDR_W'(rd_idx);
      else if (fl_erase) fl_addr = base_q;
      else               fl_addr = '0;
   end

   assign busy = busy_q;
   assign done = last;

endmodule

// File: rtl/nvm_row_ctrl.sv
module nvm_row_ctrl #(
   parameter int WORD_W    = 24,
   parameter int REG_W     = 16,
   parameter int ROW_WORDS = 64,
   parameter int PAGE_ROWS = 8,
   parameter int ADDR_W    = 16,
   parameter int OP_CYCLES = 200000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_sel,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              stall,
   output logic              fl_wr_en,
   output logic              fl_erase,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [WORD_W-1:0] fl_wdata
);
   import nvm_pkg::*;

   localparam int ROW_LG     = $clog2(ROW_WORDS);
   localparam int PAGE_WORDS = ROW_WORDS * PAGE_ROWS;
   localparam int PAGE_LG    = $clog2(PAGE_WORDS);
   localparam int BIT_GO     = REG_W - 1;
   localparam int BIT_KEYERR = REG_W - 2;
   localparam int BIT_SEQERR = REG_W - 3;
   localparam int BIT_ALIGN  = REG_W - 4;
   localparam int BIT_OP     = 0;

   // elaboration-time parameter checks
   if (WORD_W <= REG_W || WORD_W > 2 * REG_W) begin : g_bad_word
      $error("WORD_W must exceed REG_W and be at most twice REG_W");
   end
   if (REG_W < 8) begin : g_bad_reg
      $error("REG_W must hold an 8-bit key");
   end
   if ((ROW_WORDS & (ROW_WORDS - 1)) != 0 || ROW_WORDS < 2) begin : g_bad_row
      $error("ROW_WORDS must be a power of two");
   end
   if ((PAGE_ROWS & (PAGE_ROWS - 1)) != 0 || PAGE_ROWS < 1) begin : g_bad_page
      $error("PAGE_ROWS must be a power of two");
   end
   if (ADDR_W <= PAGE_LG) begin : g_bad_addr
      $error("ADDR_W must cover more than one page");
   end
   if (OP_CYCLES <= ROW_WORDS) begin : g_bad_cyc
      $error("OP_CYCLES must exceed ROW_WORDS");
   end

   logic                wr_live, ctrl_wr, go_req, clr_req, req_erase, page_ok;
   logic                armed, accept, rej_key, rej_align, rej_fill;
   logic                ld_en, ld_hi, fill_clr;
   logic                busy, done, full, seq_err;
   logic                op_q, key_err_q, align_err_q;
   logic [ADDR_W-1:0]   grp_base, start_addr;
   logic [ROW_LG-1:0]   rd_idx;
   logic [WORD_W-1:0]   rd_word;

   always_comb begin
      wr_live   = reg_wr && !busy;
      ctrl_wr   = wr_live && (reg_sel == SEL_CTRL);
      go_req    = ctrl_wr && reg_wdata[BIT_GO];
      clr_req   = ctrl_wr && !reg_wdata[BIT_GO];
      req_erase = reg_wdata[BIT_OP];
      page_ok   = (reg_addr[PAGE_LG-1:0] == '0);
      rej_key   = go_req && !armed;
      rej_align = go_req && armed && req_erase && !page_ok;
      rej_fill  = go_req && armed && !req_erase && (seq_err || !full);
      accept    = go_req && armed && !rej_align && !rej_fill;
      ld_en     = wr_live && ((reg_sel == SEL_BUF_LO) || (reg_sel == SEL_BUF_HI));
      ld_hi     = (reg_sel == SEL_BUF_HI);
      fill_clr  = clr_req || (done && !op_q);
      start_addr = req_erase ? reg_addr : grp_base;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q        <= 1'b0;
         key_err_q   <= 1'b0;
         align_err_q <= 1'b0;
      end else begin
         if (ctrl_wr) op_q <= req_erase;
         if (clr_req) begin
            key_err_q   <= 1'b0;
            align_err_q <= 1'b0;
         end else begin
            if (rej_key)   key_err_q   <= 1'b1;
            if (rej_align) align_err_q <= 1'b1;
         end
      end
   end

   nvm_unlock #(.REG_W(REG_W)) i_unlock (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_live),
      .sel   (reg_sel),
      .wdata (reg_wdata),
      .armed (armed)
   );

   nvm_fill_buf #(
      .WORD_W    (WORD_W),
      .REG_W     (REG_W),
      .ROW_WORDS (ROW_WORDS),
      .ADDR_W    (ADDR_W)
   ) i_fill (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (ld_en),
      .ld_hi    (ld_hi),
      .ld_addr  (reg_addr),
      .ld_data  (reg_wdata),
      .clr      (fill_clr),
      .flag_err (rej_fill),
      .rd_idx   (rd_idx),
      .rd_word  (rd_word),
      .full     (full),
      .seq_err  (seq_err),
      .grp_base (grp_base)
   );

   nvm_op_timer #(
      .ROW_WORDS (ROW_WORDS),
      .ADDR_W    (ADDR_W),
      .OP_CYCLES (OP_CYCLES)
   ) i_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (accept),
      .start_erase (req_erase),
      .start_addr  (start_addr),
      .busy        (busy),
      .done        (done),
      .fl_wr_en    (fl_wr_en),
      .fl_erase    (fl_erase),
      .fl_addr     (fl_addr),
      .rd_idx      (rd_idx)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_rd && (reg_sel == SEL_CTRL)) begin
         reg_rdata[BIT_GO]     = busy;
         reg_rdata[BIT_KEYERR] = key_err_q;
         reg_rdata[BIT_SEQERR] = seq_err;
         reg_rdata[BIT_ALIGN]  = align_err_q;
         reg_rdata[BIT_OP]     = op_q;
      end
   end

   assign stall    = busy;
   assign fl_wdata = fl_wr_en ? rd_word : '0;

endmodule

// File: rtl/nvm_row_ctrl_chk.sv
module nvm_row_ctrl_chk #(
   parameter int REG_W     = 16,
   parameter int ROW_WORDS = 64,
   parameter int PAGE_ROWS = 8,
   parameter int ADDR_W    = 16,
   parameter int OP_CYCLES = 200000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [1:0]        reg_sel,
   input logic [REG_W-1:0]  reg_wdata,
   input logic [REG_W-1:0]  reg_rdata,
   input logic              stall,
   input logic              fl_wr_en,
   input logic              fl_erase,
   input logic [ADDR_W-1:0] fl_addr
);
   localparam int PAGE_LG = $clog2(ROW_WORDS * PAGE_ROWS);
   localparam int LEN_W   = $clog2(OP_CYCLES + 2);

   logic [2:0]       cur_w, h0, h1, h2;
   logic [LEN_W-1:0] run_len;

   // {start write, second key, first key} for each live write
   assign cur_w = {(reg_sel == 2'd0) && reg_wdata[REG_W-1],
                   (reg_sel == 2'd1) && (reg_wdata == REG_W'(8'hAA)),
                   (reg_sel == 2'd1) && (reg_wdata == REG_W'(8'h55))};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h0 <= '0; h1 <= '0; h2 <= '0;
         run_len <= '0;
      end else begin
         if (reg_wr && !stall) begin
            h0 <= cur_w; h1 <= h0; h2 <= h1;
         end
         run_len <= stall ? run_len + LEN_W'(1) : '0;
      end
   end

   assert_key_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall) |-> (h0[2] && h1[1] && h2[0]));
   assert_stall_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stall) |-> (run_len == LEN_W'(OP_CYCLES)));
   assert_stall_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (run_len < LEN_W'(OP_CYCLES)));
   assert_go_view_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_sel == 2'd0) |-> (reg_rdata[REG_W-1] == stall));
   assert_key_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_sel == 2'd1) |-> (reg_rdata == '0));
   assert_flash_in_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_wr_en || fl_erase) |-> stall);
   assert_stream_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_wr_en && $past(fl_wr_en)) |-> (fl_addr == $past(fl_addr) + ADDR_W'(1)));
   assert_one_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fl_wr_en |-> !fl_erase);
   assert_erase_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fl_erase |-> (fl_addr[PAGE_LG-1:0] == '0));
   assert_erase_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fl_erase |=> !fl_erase);

endmodule

bind nvm_row_ctrl nvm_row_ctrl_chk #(
   .REG_W     (REG_W),
   .ROW_WORDS (ROW_WORDS),
   .PAGE_ROWS (PAGE_ROWS),
   .ADDR_W    (ADDR_W),
   .OP_CYCLES (OP_CYCLES)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_sel   (reg_sel),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .stall     (stall),
   .fl_wr_en  (fl_wr_en),
   .fl_erase  (fl_erase),
   .fl_addr   (fl_addr)
);

// File: tb/test_nvm_row_ctrl.sv
module test_nvm_row_ctrl;
   localparam int OPC = 90;
   localparam int AW  = 12;
   localparam int RW  = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic          reg_rd = 1'b0;
   logic [1:0]    reg_sel = 2'd0;
   logic [AW-1:0] reg_addr = '0;
   logic [15:0]   reg_wdata = '0;
   logic [15:0]   reg_rdata;
   logic          stall, fl_wr_en, fl_erase;
   logic [AW-1:0] fl_addr;
   logic [23:0]   fl_wdata;

   int n_chk = 0;
   int n_fail = 0;
   string cur_tag = "R1";

   always #10 clk = ~clk;

   nvm_row_ctrl #(.ADDR_W(AW), .OP_CYCLES(OPC)) i_nvm_row_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_sel(reg_sel), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .stall(stall), .fl_wr_en(fl_wr_en),
      .fl_erase(fl_erase), .fl_addr(fl_addr), .fl_wdata(fl_wdata)
   );

   task automatic chk(input string tag, input string what, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_key, m_cnt, m_base, m_fill, m_grp, m_op;
   bit m_busy, m_erase, m_half, m_keyerr, m_seqerr, m_alerr;
   int m_buf [RW];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_key = 0; m_cnt = 0; m_base = 0; m_fill = 0; m_grp = 0; m_op = 0;
         m_busy = 0; m_erase = 0; m_half = 0;
         m_keyerr = 0; m_seqerr = 0; m_alerr = 0;
         for (int i = 0; i < RW; i++) m_buf[i] = 0;
      end else if (m_busy) begin
         if (m_cnt == OPC - 1) begin
            m_busy = 0;
            if (!m_erase) begin m_fill = 0; m_half = 0; m_seqerr = 0; end
         end else m_cnt++;
      end else if (reg_wr) begin
         int s, d, a, nk;
         bit armed, hi, ok;
         s = int'(reg_sel); d = int'(reg_wdata); a = int'(reg_addr);
         nk = 0;
         if (s == 1 && d == 'h55) nk = 1;
         else if (s == 1 && d == 'hAA && m_key == 1) nk = 2;
         armed = (m_key == 2);
         m_key = nk;
         if (s == 0) begin
            m_op = d & 1;
            if (((d >> 15) & 1) == 0) begin
               m_keyerr = 0; m_alerr = 0; m_seqerr = 0; m_fill = 0; m_half = 0;
            end else if (!armed) m_keyerr = 1;
            else if ((d & 1) == 1) begin
               if (a % 512 == 0) begin m_busy = 1; m_cnt = 0; m_erase = 1; m_base = a; end
               else m_alerr = 1;
            end else begin
               if (m_seqerr || m_fill < RW) m_seqerr = 1;
               else begin m_busy = 1; m_cnt = 0; m_erase = 0; m_base = m_grp * RW; end
            end
         end else if (s >= 2) begin
            hi = (s == 3);
            ok = (m_fill < RW) && (hi == m_half) && (a % RW == m_fill) &&
                 ((m_fill == 0 && !m_half) || (a / RW == m_grp));
            if (ok) begin
               if (!hi) begin
                  m_buf[m_fill] = (m_buf[m_fill] & 'hFF0000) | d;
                  m_half = 1;
                  if (m_fill == 0) m_grp = a / RW;
               end else begin
                  m_buf[m_fill] = (m_buf[m_fill] & 'hFFFF) | ((d & 'hFF) << 16);
                  m_half = 0;
                  m_fill++;
               end
            end else m_seqerr = 1;
         end
      end
   end

   // compare every cycle, 5 ns after the falling edge
   always @(negedge clk) begin
      #5;
      if (rst_n) begin
         bit ew, ee;
         int ea, ed, er;
         ew = m_busy && !m_erase && (m_cnt < RW);
         ee = m_busy && m_erase && (m_cnt == 0);
         ea = ew ? (m_base + m_cnt) : (ee ? m_base : 0);
         ed = ew ? m_buf[m_cnt] : 0;
         er = 0;
         if (reg_rd && reg_sel == 2'd0)
            er = (int'(m_busy) << 15) | (int'(m_keyerr) << 14) |
                 (int'(m_seqerr) << 13) | (int'(m_alerr) << 12) | m_op;
         chk("R5", "stall", int'(stall), int'(m_busy));
         chk("R6", "fl_wr_en", int'(fl_wr_en), int'(ew));
         chk("R6", "fl_addr", int'(fl_addr), ea);
         chk("R6", "fl_wdata", int'(fl_wdata), ed);
         chk("R7", "fl_erase", int'(fl_erase), int'(ee));
         chk(cur_tag, "reg_rdata", int'(reg_rdata), er);
      end
   end

   // edge counters for scenario checks
   int c_stall = 0, c_wr = 0, c_er = 0, er_addr = 0;
   always @(posedge clk) if (rst_n) begin
      if (stall) c_stall++;
      if (fl_wr_en) c_wr++;
      if (fl_erase) begin c_er++; er_addr = int'(fl_addr); end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [1:0] s, input int a, input int d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = s; reg_addr = AW'(a); reg_wdata = 16'(d);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_expect(input string tag, input logic [1:0] s, input int exp);
      @(negedge clk);
      reg_rd = 1'b1; reg_sel = s;
      #6;
      chk(tag, "register read", int'(reg_rdata), exp);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic unlock();
      wr(2'd1, 0, 'h55);
      wr(2'd1, 0, 'hAA);
   endtask

   task automatic fill_row(input int grp, input int seed);
      for (int k = 0; k < RW; k++) begin
         wr(2'd2, grp * RW + k, (seed + k * 37) & 'hFFFF);
         wr(2'd3, grp * RW + k, (seed ^ k) & 'hFF);
      end
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (stall) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      int s0, w0, e0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      cur_tag = "R1";
      rd_expect("R1", 2'd0, 0);
      chk("R1", "stall after reset", int'(stall), 0);

      cur_tag = "R2";
      wr(2'd1, 0, 'h55);
      rd_expect("R2", 2'd1, 0);

      cur_tag = "R3";
      wr(2'd0, 0, 'h8000);                 // no unlock
      rd_expect("R3", 2'd0, 'h4000);
      chk("R3", "stall without unlock", int'(stall), 0);
      cur_tag = "R10";
      wr(2'd0, 0, 0);
      rd_expect("R10", 2'd0, 0);

      cur_tag = "R3";
      wr(2'd1, 0, 'h55); wr(2'd1, 0, 'h12); wr(2'd1, 0, 'hAA);
      wr(2'd0, 0, 'h8000);                 // wrong value inside key
      rd_expect("R3", 2'd0, 'h4000);
      unlock(); wr(2'd2, 0, 'h1234); wr(2'd0, 0, 'h8000); // write between key and start
      rd_expect("R3", 2'd0, 'h4000);
      wr(2'd0, 0, 0);

      cur_tag = "R6";
      fill_row(3, 'h5A5A);
      unlock();
      s0 = c_stall; w0 = c_wr;
      wr(2'd0, 0, 'h8000);
      rd_expect("R5", 2'd0, 'h8000);       // start bit visible while running
      wait_idle();
      rd_expect("R5", 2'd0, 0);            // cleared by hardware
      chk("R5", "stall cycles", c_stall - s0, OPC);
      chk("R6", "word writes", c_wr - w0, RW);

      cur_tag = "R9";
      unlock(); wr(2'd0, 0, 'h8000);       // buffer rewound, empty
      rd_expect("R9", 2'd0, 'h2000);
      chk("R9", "no stall on empty buffer", int'(stall), 0);
      wr(2'd0, 0, 0);

      cur_tag = "R8";
      wr(2'd2, 64, 'h1111); wr(2'd3, 64, 'h22); wr(2'd2, 66, 'h3333); // skipped address
      rd_expect("R8", 2'd0, 'h2000);
      unlock(); wr(2'd0, 0, 'h8000);
      rd_expect("R9", 2'd0, 'h2000);
      wr(2'd0, 0, 0);
      wr(2'd2, 65, 'h4444);                // start not row aligned
      rd_expect("R8", 2'd0, 'h2000);
      wr(2'd0, 0, 0);
      wr(2'd3, 0, 'h55);                   // high half before low half
      rd_expect("R8", 2'd0, 'h2000);
      wr(2'd0, 0, 0);

      cur_tag = "R7";
      unlock(); wr(2'd0, 'h240, 'h8001);
      rd_expect("R7", 2'd0, 'h1001);
      chk("R7", "no stall on misaligned erase", int'(stall), 0);
      wr(2'd0, 0, 1);
      rd_expect("R4", 2'd0, 1);            // op field reads back
      e0 = c_er; s0 = c_stall; w0 = c_wr;
      unlock(); wr(2'd0, 'h400, 'h8001);
      wait_idle();
      chk("R7", "erase pulses", c_er - e0, 1);
      chk("R7", "erase address", er_addr, 'h400);
      chk("R4", "erase writes no words", c_wr - w0, 0);
      chk("R5", "erase stall cycles", c_stall - s0, OPC);
      rd_expect("R4", 2'd0, 1);

      cur_tag = "R11";
      wr(2'd0, 0, 0);
      fill_row(5, 'h0F0F);
      unlock(); wr(2'd0, 0, 'h8000);
      wr(2'd1, 0, 'h55); wr(2'd1, 0, 'hAA); // made while stalled
      wait_idle();
      wr(2'd0, 0, 'h8000);
      rd_expect("R11", 2'd0, 'h4000);
      chk("R11", "no stall after ignored key", int'(stall), 0);

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule